// File: doc/BRIEF.md
# Offset Register Load Sequencer

This block holds the two threshold values that a synchronous FIFO's partial flags compare against: the empty-side offset and the full-side offset, each 12 bits wide. One shared configuration-select input turns each enabled access into an offset access rather than a FIFO access. An offset write on the write clock takes its value from the low bits of the write data. An offset read on the read clock returns the value on the read data output. The block also tells the FIFO, on each clock, whether the access is a real push or pop.

Each clock side keeps its own one-bit selection pointer. Successive offset accesses on a side alternate between the empty offset and the full offset, starting with the empty offset. A pointer keeps its position when configuration select drops, so a programming session can stop after one register and resume later with the other. A write and a read must never touch the offsets in the same cycle. The user of the block has to make sure of this.

Top module: `offset_load_seq`

## Requirements
- R1: After reset both offsets hold the default for the configured depth. The default is 0x01F for depth 256 or less, 0x03F for depth 512 or less, and 0x07F otherwise (0x07F for the default depth of 1024). Both selection pointers point at the empty offset (pointer output 0), `rd_data` is zero, and `fifo_push` and `fifo_pop` are low.
- R2: With `cfg_sel` and `wr_req` high, each write clock edge loads `wr_data[11:0]` into the register named by the write pointer and then toggles the pointer. The order is empty (pointer 0), full (pointer 1), then empty again.
- R3: With `cfg_sel` high and `wr_req` low, a write clock edge changes neither offset nor the write pointer.
- R4: With `cfg_sel` low and `wr_req` high, `fifo_push` is high in that same cycle and the offsets and write pointer are untouched. With `cfg_sel` high, `fifo_push` stays low.
- R5: Dropping `cfg_sel` between offset writes keeps the write pointer where it was, so the next offset write goes to the register that follows in the sequence.
- R6: With `cfg_sel` and `rd_req` high, each read clock edge places the offset named by the read pointer on `rd_data[11:0]`, with `rd_data[17:12]` zero, and then toggles the read pointer. The order is empty, full, empty.
- R7: The read pointer moves only on offset reads and the write pointer moves only on offset writes. Neither access moves the other side's pointer.
- R8: With `rd_req` low, `rd_data` holds its value. With `cfg_sel` low and `rd_req` high, `fifo_pop` is high in that cycle and `rd_data` takes `mem_rdata` at the edge.
- R9: Write data bits above bit 11 have no effect on the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| cfg_sel | input | 1 | High: enabled accesses target the offset registers |
| wr_req | input | 1 | Write-side access enable |
| wr_data | input | 18 | Write data; low 12 bits feed the offsets |
| rd_req | input | 1 | Read-side access enable |
| mem_rdata | input | 18 | Word from the FIFO array for normal reads |
| fifo_push | output | 1 | Current write access is a FIFO write |
| fifo_pop | output | 1 | Current read access is a FIFO read |
| empty_ofs | output | 12 | Empty-side offset value |
| full_ofs | output | 12 | Full-side offset value |
| wr_tgt_full | output | 1 | Write pointer: 0 empty offset next, 1 full offset next |
| rd_tgt_full | output | 1 | Read pointer: 0 empty offset next, 1 full offset next |
| rd_data | output | 18 | Read output register |

## Verification
The checker watches several rules on every edge of its clock. After each offset write the write pointer must toggle. A configuration cycle without a write and any normal FIFO access must leave the offsets and the write pointer unchanged. An offset read must put zeros in the upper output bits. The output must hold whenever no read is requested. Offsets may never be written and read in the same cycle. Other points need the directed scenarios: the exact empty-full-empty order, the values loaded, the depth-dependent default, resuming after a partial session, independence of the two pointers, and the upper data bits being ignored.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic cfg;   // access targets an offset register
        logic fifo;  // access targets the FIFO array
    } acc_t;

    function automatic acc_t decode_acc(input logic sel, input logic req);
        acc_t a;
        a.cfg  = sel & req;
        a.fifo = ~sel & req;
        return a;
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

    function automatic int unsigned default_ofs(input int unsigned depth);
        if (depth <= 256) return 31;
        if (depth <= 512) return 63;
        return 127;
    endfunction

endpackage

// File: rtl/ofs_access_decode.sv
module ofs_access_decode
    import ofs_pkg::*;
(
    input  logic cfg_sel,
    input  logic req,
    output acc_t acc
);
    always_comb acc = decode_acc(cfg_sel, req);
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output ofs_sel_e          sel
);
    localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(default_ofs(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= SEL_EMPTY;
            empty_ofs <= DEF_OFS;
            full_ofs  <= DEF_OFS;
        end else if (acc.cfg) begin
            if (sel == SEL_EMPTY) empty_ofs <= din[OFS_W-1:0];
            else                  full_ofs  <= din[OFS_W-1:0];
            sel <= next_sel(sel);
        end
    end
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output ofs_sel_e          sel,
    output logic [DATA_W-1:0] dout
);
    logic [OFS_W-1:0] picked;

    always_comb picked = (sel == SEL_EMPTY) ? empty_ofs : full_ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= SEL_EMPTY;
            dout <= '0;
        end else if (acc.cfg) begin
            dout <= DATA_W'(picked);
            sel  <= next_sel(sel);
        end else if (acc.fifo) begin
            dout <= mem_rdata;
        end
    end
endmodule

// File: rtl/offset_load_seq.sv
module offset_load_seq
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              cfg_sel,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic              wr_tgt_full,
    output logic              rd_tgt_full,
    output logic [DATA_W-1:0] rd_data
);
    acc_t     wr_acc, rd_acc;
    ofs_sel_e wr_sel, rd_sel;

    ofs_access_decode u_wr_dec (.cfg_sel(cfg_sel), .req(wr_req), .acc(wr_acc));
    ofs_access_decode u_rd_dec (.cfg_sel(cfg_sel), .req(rd_req), .acc(rd_acc));

    ofs_wr_bank #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) u_bank (
        .clk(wr_clk), .rst(rst), .acc(wr_acc), .din(wr_data),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .sel(wr_sel)
    );

    ofs_rd_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
        .clk(rd_clk), .rst(rst), .acc(rd_acc),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .mem_rdata(mem_rdata),
        .sel(rd_sel), .dout(rd_data)
    );

    always_comb begin
        fifo_push   = wr_acc.fifo;
        fifo_pop    = rd_acc.fifo;
        wr_tgt_full = (wr_sel == SEL_FULL);
        rd_tgt_full = (rd_sel == SEL_FULL);
    end
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst,
    input logic              cfg_sel,
    input logic              wr_req,
    input logic              rd_req,
    input logic [OFS_W-1:0]  empty_ofs,
    input logic [OFS_W-1:0]  full_ofs,
    input logic              wr_tgt_full,
    input logic [DATA_W-1:0] rd_data
);
    // R2
    wr_ptr_toggle_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (cfg_sel && wr_req) |=> (wr_tgt_full != $past(wr_tgt_full)));

    // R3
    cfg_idle_hold_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (cfg_sel && !wr_req) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_tgt_full)));

    // R4
    fifo_wr_no_ofs_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (!cfg_sel) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_tgt_full)));

    // R6
    rb_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (cfg_sel && rd_req) |=> (rd_data[DATA_W-1:OFS_W] == '0));

    // R6
    cfg_collision_chk: assert property (@(posedge wr_clk) disable iff (rst)
        !(cfg_sel && wr_req && rd_req));

    // R8
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (!rd_req) |=> $stable(rd_data));
endmodule

bind offset_load_seq ofs_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) i_ofs_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .cfg_sel(cfg_sel),
    .wr_req(wr_req), .rd_req(rd_req), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .wr_tgt_full(wr_tgt_full), .rd_data(rd_data)
);

// File: tb/test_offset_load_seq.sv
module test_offset_load_seq;
    localparam int DW = 18;
    localparam int OW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sel = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0, mem_rdata = '0;
    logic fifo_push, fifo_pop, wr_tgt_full, rd_tgt_full;
    logic [OW-1:0] empty_ofs, full_ofs;
    logic [DW-1:0] rd_data;
    logic seen_push, seen_pop;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    offset_load_seq i_offset_load_seq (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .cfg_sel(cfg_sel),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
        .mem_rdata(mem_rdata), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .wr_tgt_full(wr_tgt_full),
        .rd_tgt_full(rd_tgt_full), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one cycle with the given inputs, then back to idle
    task automatic step(input logic c, input logic w, input logic r,
                        input logic [DW-1:0] d, input logic [DW-1:0] m);
        @(negedge clk);
        cfg_sel = c; wr_req = w; rd_req = r; wr_data = d; mem_rdata = m;
        #1;
        seen_push = fifo_push;
        seen_pop  = fifo_pop;
        @(negedge clk);
        cfg_sel = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 empty_ofs", 32'(empty_ofs), 32'h07F);
        chk("R1 full_ofs", 32'(full_ofs), 32'h07F);
        chk("R1 wr ptr", 32'(wr_tgt_full), 0);
        chk("R1 rd ptr", 32'(rd_tgt_full), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 push/pop", 32'({fifo_push, fifo_pop}), 0);
    endtask

    task automatic t_sequence;
        do_reset();
        step(1, 1, 0, 18'h3F155, 0);
        chk("R2 first->empty", 32'(empty_ofs), 32'h155);
        chk("R9 upper bits ignored", 32'(empty_ofs), 32'h155);
        chk("R2 full kept", 32'(full_ofs), 32'h07F);
        chk("R2 ptr->full", 32'(wr_tgt_full), 1);
        chk("R4 no push on cfg", 32'(seen_push), 0);
        step(1, 1, 0, 18'h002AA, 0);
        chk("R2 second->full", 32'(full_ofs), 32'h2AA);
        chk("R2 ptr->empty", 32'(wr_tgt_full), 0);
        step(1, 1, 0, 18'h000F0, 0);
        chk("R2 third->empty", 32'(empty_ofs), 32'h0F0);
        chk("R2 full unchanged", 32'(full_ofs), 32'h2AA);
    endtask

    task automatic t_idle_cfg;
        // write pointer currently at full
        for (int i = 0; i < 3; i++) step(1, 0, 0, 18'h00ABC, 0);
        chk("R3 ptr held", 32'(wr_tgt_full), 1);
        chk("R3 empty held", 32'(empty_ofs), 32'h0F0);
        chk("R3 full held", 32'(full_ofs), 32'h2AA);
    endtask

    task automatic t_partial;
        do_reset();
        step(1, 1, 0, 18'h00011, 0);
        step(0, 1, 0, 18'h00FFF, 0);
        chk("R4 push high", 32'(seen_push), 1);
        chk("R4 offsets untouched", 32'({empty_ofs, full_ofs}), 32'({12'h011, 12'h07F}));
        chk("R5 ptr kept", 32'(wr_tgt_full), 1);
        step(1, 1, 0, 18'h00022, 0);
        chk("R5 resume->full", 32'(full_ofs), 32'h022);
        chk("R5 empty kept", 32'(empty_ofs), 32'h011);
    endtask

    task automatic t_readback;
        // offsets: empty 0x011, full 0x022, write pointer at empty
        step(1, 0, 1, 0, 18'h3FFFF);
        chk("R6 first read empty", 32'(rd_data), 32'h011);
        chk("R7 rd ptr moved", 32'(rd_tgt_full), 1);
        chk("R7 wr ptr unmoved", 32'(wr_tgt_full), 0);
        chk("R8 no pop on cfg", 32'(seen_pop), 0);
        step(1, 0, 1, 0, 0);
        chk("R6 second read full", 32'(rd_data), 32'h022);
        step(1, 0, 1, 0, 0);
        chk("R6 third read empty", 32'(rd_data), 32'h011);
        step(1, 1, 0, 18'h00033, 0);
        chk("R7 write uses own ptr", 32'(empty_ofs), 32'h033);
        chk("R7 rd ptr unmoved by write", 32'(rd_tgt_full), 1);
        step(1, 0, 1, 0, 0);
        chk("R6 fourth read full", 32'(rd_data), 32'h022);
    endtask

    task automatic t_fifo_read;
        step(0, 0, 0, 0, 18'h12345);
        chk("R8 hold", 32'(rd_data), 32'h022);
        step(0, 0, 1, 0, 18'h2BEEF);
        chk("R8 pop high", 32'(seen_pop), 1);
        chk("R8 mem data", 32'(rd_data), 32'h2BEEF);
        chk("R7 rd ptr unmoved by pop", 32'(rd_tgt_full), 0);
        step(1, 0, 0, 0, 18'h00001);
        chk("R8 hold cfg idle", 32'(rd_data), 32'h2BEEF);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sequence();
                t_idle_cfg();
                t_partial();
                t_readback();
                t_fifo_read();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule